// File: doc/BRIEF.md
# Configurable Set/Reset Storage Cell

A one-bit storage element of the type placed next to an I/O pad. Elaboration-time parameters choose whether it is an edge-triggered flip-flop or a level-sensitive latch. They also choose which of seven force-control arrangements it has and whether those forces are synchronous or asynchronous. They set the polarity of each control pin and the value loaded by the init pulse.

The cell has two force pins. The primary force drives the stored bit to a programmed force value, which is either 0 or 1. The opposite force drives the bit to the complement of that value. Each pin maps onto a set direction (to 1) or a reset direction (to 0), according to the force value. A direction that the chosen control arrangement does not provide is dropped. If both directions are requested at once, the reset direction wins. The init pulse is asynchronous and overrides everything else. By default it loads the force value. A separate parameter can replace that value.

Top module: `cfgcell`

## Requirements
- R1: While `init_i` is high, `q_o` equals the init value at once, whatever the clock, enable, data and force inputs are doing.
- R2: When `INIT_VAL` is negative (the default), the init value equals `FORCE_VAL`. When `INIT_VAL` is 0 or 1, the init value is that number, independent of `FORCE_VAL`.
- R3: An active primary force drives `q_o` to `FORCE_VAL`, provided that direction exists in `CTRL`.
- R4: An active opposite force drives `q_o` to the complement of `FORCE_VAL`, provided that direction exists in `CTRL`.
- R5: When set-direction and reset-direction requests are both active, `q_o` becomes 0. This holds in both synchronous and asynchronous arrangements.
- R6: `CTRL` codes 0..6 mean, in order: none, sync set, sync reset, sync set+reset, async set, async reset, async set+reset. A force whose direction is absent in the selected code has no effect, and the cell then behaves as if that pin were inactive.
- R7: Synchronous forces change `q_o` only at an active clock edge (or during an open latch phase) with the enable asserted. Between edges they have no effect.
- R8: Asynchronous forces change `q_o` immediately with no clock, and they override the enable.
- R9: With the enable deasserted, the cell holds its value at clock edges. With `CE_USED`=0, the enable pin is ignored and the cell is always enabled. Otherwise the value at the active edge is loaded from `d_i`.
- R10: With `LATCH_MODE`=1, `q_o` follows `d_i` while the gate is active and the enable is asserted, and holds while the gate is inactive.
- R11: When `CLK_INV`, `CE_INV`, `FRC_INV` or `OPP_INV` is 1, the matching pin is active low. For the clock, this means the falling edge or the low gate level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (flip-flop mode) or gate (latch mode), polarity set by CLK_INV |
| init_i | input | 1 | Active-high asynchronous init pulse, loads the init value |
| d_i | input | 1 | Data input |
| ce_i | input | 1 | Enable, polarity set by CE_INV, ignored when CE_USED=0 |
| frc_i | input | 1 | Primary force, drives to FORCE_VAL |
| opp_i | input | 1 | Opposite force, drives to the complement of FORCE_VAL |
| q_o | output | 1 | Stored bit |

## Verification
The hardest cases to reach are those where an input that is present must still have no effect. Examples are a force whose direction the control code drops, an enable with `CE_USED`=0, and a synchronous force held between clock edges. Each appears only in certain parameter combinations. The bench therefore builds 56 instances covering every control code, both force values, both storage kinds and both polarity sets, with the explicit init value and the unused enable spread across them. Every instance is driven from the same 16 input combinations in several orders. The output is sampled before the edge, during the active phase and after it, so that a missed edge or an early force shows up as a mismatch.

// File: rtl/cfgcell_pkg.sv
package cfgcell_pkg;

  typedef enum logic [2:0] {
    CTRL_NONE       = 3'd0,
    CTRL_SYNC_SET   = 3'd1,
    CTRL_SYNC_RST   = 3'd2,
    CTRL_SYNC_BOTH  = 3'd3,
    CTRL_ASYNC_SET  = 3'd4,
    CTRL_ASYNC_RST  = 3'd5,
    CTRL_ASYNC_BOTH = 3'd6
  } ctrl_e;

  function automatic bit has_set_dir(ctrl_e c);
    return (c == CTRL_SYNC_SET) || (c == CTRL_SYNC_BOTH) ||
           (c == CTRL_ASYNC_SET) || (c == CTRL_ASYNC_BOTH);
  endfunction

  function automatic bit has_rst_dir(ctrl_e c);
    return (c == CTRL_SYNC_RST) || (c == CTRL_SYNC_BOTH) ||
           (c == CTRL_ASYNC_RST) || (c == CTRL_ASYNC_BOTH);
  endfunction

  function automatic bit is_async(ctrl_e c);
    return (c == CTRL_ASYNC_SET) || (c == CTRL_ASYNC_RST) ||
           (c == CTRL_ASYNC_BOTH);
  endfunction

endpackage

// File: rtl/cfgcell_pol.sv
module cfgcell_pol #(
  parameter bit CLK_INV = 1'b0,
  parameter bit CE_INV  = 1'b0,
  parameter bit FRC_INV = 1'b0,
  parameter bit OPP_INV = 1'b0,
  parameter bit CE_USED = 1'b1
) (
  input  logic clk_i,
  input  logic ce_i,
  input  logic frc_i,
  input  logic opp_i,
  output logic clk_e,
  output logic ce_e,
  output logic frc_e,
  output logic opp_e
);

  assign clk_e = clk_i ^ CLK_INV;
  assign frc_e = frc_i ^ FRC_INV;
  assign opp_e = opp_i ^ OPP_INV;

  generate
    if (CE_USED) begin : g_ce
      assign ce_e = ce_i ^ CE_INV;
    end else begin : g_ce_tied
      assign ce_e = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/cfgcell_resolve.sv
module cfgcell_resolve
  import cfgcell_pkg::*;
#(
  parameter ctrl_e CTRL      = CTRL_SYNC_BOTH,
  parameter bit    FORCE_VAL = 1'b0
) (
  input  logic frc_e,
  input  logic opp_e,
  output logic set_rq,
  output logic rst_rq
);

  localparam bit HAS_SET = has_set_dir(CTRL);
  localparam bit HAS_RST = has_rst_dir(CTRL);

  logic to_one;
  logic to_zero;

  // primary force goes toward FORCE_VAL, opposite force toward its complement
  assign to_one  = FORCE_VAL ? frc_e : opp_e;
  assign to_zero = FORCE_VAL ? opp_e : frc_e;

  generate
    if (HAS_SET) begin : g_set
      assign set_rq = to_one;
    end else begin : g_noset
      assign set_rq = 1'b0;
    end
    if (HAS_RST) begin : g_rst
      assign rst_rq = to_zero;
    end else begin : g_norst
      assign rst_rq = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cfgcell_ff_sync.sv
module cfgcell_ff_sync #(
  parameter bit INIT_BIT = 1'b0
) (
  input  logic clk_e,
  input  logic init_i,
  input  logic ce_e,
  input  logic d_i,
  input  logic set_rq,
  input  logic rst_rq,
  output logic q
);

  always_ff @(posedge clk_e or posedge init_i) begin
    if (init_i) begin
      q <= INIT_BIT;
    end else if (ce_e) begin
      if (rst_rq)      q <= 1'b0;
      else if (set_rq) q <= 1'b1;
      else             q <= d_i;
    end
  end

  // R5
  sync_rst_chk: assert property (@(posedge clk_e) disable iff (init_i)
    (ce_e && rst_rq) |=> (q == 1'b0));

  // R3
  sync_set_chk: assert property (@(posedge clk_e) disable iff (init_i)
    (ce_e && set_rq && !rst_rq) |=> (q == 1'b1));

  // R9
  sync_load_chk: assert property (@(posedge clk_e) disable iff (init_i)
    (ce_e && !set_rq && !rst_rq) |=> (q == $past(d_i)));

  // R9
  sync_hold_chk: assert property (@(posedge clk_e) disable iff (init_i)
    (!ce_e) |=> (q == $past(q)));

endmodule

// File: rtl/cfgcell_ff_async.sv
module cfgcell_ff_async #(
  parameter bit INIT_BIT = 1'b0
) (
  input  logic clk_e,
  input  logic init_i,
  input  logic ce_e,
  input  logic d_i,
  input  logic set_rq,
  input  logic rst_rq,
  output logic q
);

  always_ff @(posedge clk_e or posedge init_i or posedge rst_rq or posedge set_rq) begin
    if (init_i)      q <= INIT_BIT;
    else if (rst_rq) q <= 1'b0;
    else if (set_rq) q <= 1'b1;
    else if (ce_e)   q <= d_i;
  end

  // R8
  async_clr_chk: assert property (@(posedge clk_e) disable iff (init_i)
    rst_rq |-> (q == 1'b0));

  // R8
  async_pre_chk: assert property (@(posedge clk_e) disable iff (init_i)
    (set_rq && !rst_rq) |-> (q == 1'b1));

endmodule

// File: rtl/cfgcell_latch.sv
module cfgcell_latch #(
  parameter bit INIT_BIT = 1'b0,
  parameter bit ASYNC    = 1'b0
) (
  input  logic gate_e,
  input  logic init_i,
  input  logic ce_e,
  input  logic d_i,
  input  logic set_rq,
  input  logic rst_rq,
  output logic q
);

  logic a_rst;
  logic a_set;
  logic s_rst;
  logic s_set;
  logic open_ph;

  generate
    if (ASYNC) begin : g_async
      assign a_rst = rst_rq;
      assign a_set = set_rq;
      assign s_rst = 1'b0;
      assign s_set = 1'b0;
    end else begin : g_sync
      assign a_rst = 1'b0;
      assign a_set = 1'b0;
      assign s_rst = rst_rq;
      assign s_set = set_rq;
    end
  endgenerate

  assign open_ph = gate_e & ce_e;

  always_latch begin
    if (init_i)       q = INIT_BIT;
    else if (a_rst)   q = 1'b0;
    else if (a_set)   q = 1'b1;
    else if (open_ph) begin
      if (s_rst)      q = 1'b0;
      else if (s_set) q = 1'b1;
      else            q = d_i;
    end
  end

endmodule

// File: rtl/cfgcell.sv
module cfgcell
  import cfgcell_pkg::*;
#(
  parameter bit    LATCH_MODE = 1'b0,
  parameter ctrl_e CTRL       = CTRL_SYNC_BOTH,
  parameter bit    FORCE_VAL  = 1'b0,
  parameter int    INIT_VAL   = -1,
  parameter bit    CE_USED    = 1'b1,
  parameter bit    CLK_INV    = 1'b0,
  parameter bit    CE_INV     = 1'b0,
  parameter bit    FRC_INV    = 1'b0,
  parameter bit    OPP_INV    = 1'b0
) (
  input  logic clk_i,
  input  logic init_i,
  input  logic d_i,
  input  logic ce_i,
  input  logic frc_i,
  input  logic opp_i,
  output logic q_o
);

  localparam bit INIT_BIT = (INIT_VAL < 0) ? FORCE_VAL : (INIT_VAL != 0);
  localparam bit ASYNC    = is_async(CTRL);

  logic clk_e, ce_e, frc_e, opp_e;
  logic set_rq, rst_rq;

  cfgcell_pol #(
    .CLK_INV(CLK_INV), .CE_INV(CE_INV), .FRC_INV(FRC_INV),
    .OPP_INV(OPP_INV), .CE_USED(CE_USED)
  ) u_pol (
    .clk_i(clk_i), .ce_i(ce_i), .frc_i(frc_i), .opp_i(opp_i),
    .clk_e(clk_e), .ce_e(ce_e), .frc_e(frc_e), .opp_e(opp_e)
  );

  cfgcell_resolve #(.CTRL(CTRL), .FORCE_VAL(FORCE_VAL)) u_res (
    .frc_e(frc_e), .opp_e(opp_e), .set_rq(set_rq), .rst_rq(rst_rq)
  );

  generate
    if (LATCH_MODE) begin : g_latch
      cfgcell_latch #(.INIT_BIT(INIT_BIT), .ASYNC(ASYNC)) u_store (
        .gate_e(clk_e), .init_i(init_i), .ce_e(ce_e), .d_i(d_i),
        .set_rq(set_rq), .rst_rq(rst_rq), .q(q_o)
      );
    end else if (ASYNC) begin : g_ff_async
      cfgcell_ff_async #(.INIT_BIT(INIT_BIT)) u_store (
        .clk_e(clk_e), .init_i(init_i), .ce_e(ce_e), .d_i(d_i),
        .set_rq(set_rq), .rst_rq(rst_rq), .q(q_o)
      );
    end else begin : g_ff_sync
      cfgcell_ff_sync #(.INIT_BIT(INIT_BIT)) u_store (
        .clk_e(clk_e), .init_i(init_i), .ce_e(ce_e), .d_i(d_i),
        .set_rq(set_rq), .rst_rq(rst_rq), .q(q_o)
      );
    end
  endgenerate

  // R1
  init_prio_chk: assert property (@(posedge clk_e)
    init_i |-> (q_o == INIT_BIT));

endmodule

// File: tb/cfgcell_bench.sv
module cfgcell_bench;
  import cfgcell_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int Q4 = CLK_PERIOD / 4;
  localparam int NCFG = 56;

  logic clk_l = 1'b0;
  logic init  = 1'b0;
  logic d     = 1'b0;
  logic ce    = 1'b0;
  logic frc   = 1'b0;
  logic opp   = 1'b0;
  logic q_all [NCFG];
  bit   expv  [NCFG];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic int  ctrl_of(int i);  return i % 7;             endfunction
  function automatic bit  fv_of(int i);    return ((i / 7) % 2) != 0; endfunction
  function automatic bit  lat_of(int i);   return ((i / 14) % 2) != 0; endfunction
  function automatic bit  inv_of(int i);   return ((i / 28) % 2) != 0; endfunction
  function automatic bit  ceu_of(int i);   return (i % 5) != 0;      endfunction
  function automatic bit  expl_of(int i);  return (i % 3) == 0;      endfunction
  // explicit init value is the complement of the force value (R2)
  function automatic bit  initv_of(int i); return expl_of(i) ? !fv_of(i) : fv_of(i); endfunction

  function automatic bit hs(int i); int c = ctrl_of(i); return c==1||c==3||c==4||c==6; endfunction
  function automatic bit hr(int i); int c = ctrl_of(i); return c==2||c==3||c==5||c==6; endfunction
  function automatic bit asy(int i); return ctrl_of(i) >= 4; endfunction
  function automatic bit sreq(int i); return hs(i) && (fv_of(i) ? frc : opp); endfunction
  function automatic bit rreq(int i); return hr(i) && (fv_of(i) ? opp : frc); endfunction

  function automatic bit nxt(int i, bit cur, bit active);
    bit ceff = ceu_of(i) ? ce : 1'b1;
    if (asy(i)) begin
      if (rreq(i)) return 1'b0;
      if (sreq(i)) return 1'b1;
    end
    if (!active || !ceff) return cur;
    if (rreq(i)) return 1'b0;
    if (sreq(i)) return 1'b1;
    return d;
  endfunction

  function automatic string tag(int i, bit active);
    string s;
    bit ceff = ceu_of(i) ? ce : 1'b1;
    if (init) s = "R1 R2";
    else if (rreq(i) && sreq(i)) s = "R5";
    else if ((frc || opp) && !(rreq(i) || sreq(i))) s = "R6";
    else if (rreq(i) || sreq(i)) begin
      s = (sreq(i) == fv_of(i) && (sreq(i) || rreq(i)) && (fv_of(i) ? frc : !frc || !opp) && frc) ? "R3" : "R4";
      s = {s, asy(i) ? " R8" : " R7"};
    end
    else if (!ceff || !ceu_of(i)) s = "R9";
    else if (lat_of(i)) s = active ? "R10" : "R10 hold";
    else s = "R9";
    if (inv_of(i)) s = {s, " R11"};
    return s;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < NCFG; gi++) begin : g_cfg
      localparam bit    INV  = ((gi / 28) % 2) != 0;
      localparam ctrl_e CT   = ctrl_e'(gi % 7);
      localparam bit    FV   = ((gi / 7) % 2) != 0;
      localparam bit    LT   = ((gi / 14) % 2) != 0;
      localparam bit    CEU  = (gi % 5) != 0;
      localparam int    IV   = ((gi % 3) == 0) ? (FV ? 0 : 1) : -1;
      logic q;
      cfgcell #(
        .LATCH_MODE(LT), .CTRL(CT), .FORCE_VAL(FV), .INIT_VAL(IV), .CE_USED(CEU),
        .CLK_INV(INV), .CE_INV(INV), .FRC_INV(INV), .OPP_INV(INV)
      ) u_cfgcell (
        .clk_i(clk_l ^ INV), .init_i(init), .d_i(d), .ce_i(ce ^ INV),
        .frc_i(frc ^ INV), .opp_i(opp ^ INV), .q_o(q)
      );
      assign q_all[gi] = q;
    end
  endgenerate

  task automatic check_all(bit active, string where);
    for (int i = 0; i < NCFG; i++) begin
      n_cmp++;
      if (q_all[i] !== expv[i]) begin
        n_bad++;
        $display("FAIL %s cfg=%0d (%s) actual=%b expected=%b", tag(i, active), i, where, q_all[i], expv[i]);
      end
    end
  endtask

  task automatic cycle_clk(bit do_update);
    #(Q4) clk_l = 1'b1;
    #(Q4);
    if (do_update) for (int i = 0; i < NCFG; i++) expv[i] = nxt(i, expv[i], 1'b1);
    check_all(1'b1, "active phase");
    #(Q4) clk_l = 1'b0;
    #(Q4);
    check_all(1'b0, "after phase");
  endtask

  // init pulse spanning a clock edge; forces released before init falls
  task automatic init_pulse(bit f, bit o);
    frc = f; opp = o;
    #1 init = 1'b1;
    #(Q4);
    for (int i = 0; i < NCFG; i++) expv[i] = initv_of(i);
    check_all(1'b0, "init held"); // R1
    cycle_clk(1'b0);
    frc = 1'b0; opp = 1'b0;
    #1 init = 1'b0;
    #(Q4);
    check_all(1'b0, "init released"); // R2
  endtask

  task automatic step(int v);
    frc = 1'b0; opp = 1'b0;
    #1;
    d = v[0]; ce = v[1]; frc = v[2]; opp = v[3];
    #(Q4);
    for (int i = 0; i < NCFG; i++) expv[i] = nxt(i, expv[i], 1'b0);
    check_all(1'b0, "between edges"); // R7 R8
    cycle_clk(1'b1);
  endtask

  initial begin
    #1;
    init_pulse(1'b0, 1'b0);
    for (int rep = 0; rep < 4; rep++) begin
      for (int k = 0; k < 16; k++) begin
        step((k * 7 + rep * 5) % 16);
        step(k ^ 4'b0001);
      end
      init_pulse(rep[0], rep[1]);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule